// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block produces all the refresh traffic for a 1024-row DRAM that refreshes with CAS-before-RAS cycles. The DRAM's internal row counter picks the row, so the block drives only the two strobes and never the address, write-enable or output-enable lines. After reset it holds the strobes idle for the power-up pause. It then runs a fixed number of initialization refresh cycles on its own. Only after that does it report that normal accesses may start.

In normal operation an interval timer adds one unit to a refresh debt each period. Any nonzero debt raises a request to the access controller. When the controller grants it, the scheduler waits until the controller reports its row closed, then runs the strobe sequence: CAS falls, RAS falls, CAS rises while RAS is still low, RAS rises, then precharge. Each completed cycle pays back one unit of debt. When the debt reaches its limit, an urgent flag tells the controller to stop starting new accesses. If no access and no refresh occurs for longer than the idle limit, the block leaves normal operation and runs the initialization cycles again.

All timing is in clock cycles. The defaults assume a 100 MHz clock: a 200 µs pause, a 15.6 µs interval, an 8 ms idle limit, and strobe phases that meet a 60 ns RAS-low time, a 40 ns precharge time and 5/10 ns CAS setup and hold times. The parameters must satisfy CHR_CYC < RAS_LOW_CYC, and every cycle count must be at least 1.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, and whenever no refresh sequence is running, cas_n_o and ras_n_o are both high, ref_req_o and ref_busy_o are low, and init_done_o is low during reset.
- R2: After reset is released the strobes stay high for at least PAUSE_CYC clock cycles before the first CAS fall.
- R3: After the pause exactly INIT_CBR_NUM refresh cycles run without any grant before init_done_o rises, and ref_req_o is never high while init_done_o is low.
- R4: In each refresh cycle cas_n_o is low for exactly CSR_CYC cycles before ras_n_o falls, and stays low for exactly CHR_CYC cycles once ras_n_o is low.
- R5: ras_n_o stays low for exactly RAS_LOW_CYC cycles, and it rises with cas_n_o already high. At least RAS_PRE_CYC cycles with both strobes high follow before CAS falls again.
- R6: After a grant, cas_n_o does not fall while row_open_i is high. CAS falls in the cycle after the first clock edge at which row_open_i is low.
- R7: Once initialization is done, each REF_INTERVAL_CYC cycles adds one unit of debt. ref_req_o is high whenever the debt is nonzero and no sequence is running, and it holds while ref_gnt_i stays low.
- R8: Each completed refresh cycle removes one unit of debt. With ref_gnt_i held high the request falls once the debt is paid.
- R9: The debt saturates at DEBT_LIMIT. ref_urgent_o is high exactly while the debt equals DEBT_LIMIT.
- R10: After init is done, if IDLE_LIMIT_CYC cycles pass with no access_cycle_i pulse and no refresh activity, init_done_o falls and INIT_CBR_NUM further refresh cycles run before it rises again.
- R11: Any access_cycle_i pulse restarts the idle gap count, so accesses spaced closer than IDLE_LIMIT_CYC keep init_done_o high.
- R12: ref_gnt_i is ignored while ref_req_o is low. A grant taken with ref_req_o high raises ref_busy_o on the next cycle and drops ref_req_o until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_open_i | input | 1 | Access controller currently holds a row open (its RAS low) |
| access_cycle_i | input | 1 | One-cycle pulse for each access cycle the controller runs |
| ref_gnt_i | input | 1 | Grant from the access controller for a pending refresh |
| ref_req_o | output | 1 | Refresh debt pending, scheduler idle |
| ref_urgent_o | output | 1 | Debt at limit; controller must hold off new accesses |
| ref_busy_o | output | 1 | Scheduler owns the strobes |
| init_done_o | output | 1 | Pause and initialization done; accesses allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe (drives both byte strobes), active low |

## Verification
The hardest case to reach is the fall back into initialization after a long idle gap. It needs normal operation to continue with no refresh being granted and no accesses occurring for the full idle limit. Meanwhile the debt has to sit saturated and the urgent flag has to be raised. The stimulus withholds the grant for a stretch kept alive by accesses spaced below the limit, then stops the accesses. It expects the done flag to drop and eight more strobe sequences to run. A second hard case is a grant that arrives while the controller still holds its row open. The bench holds row_open_i high for many cycles after granting and watches CAS stay high.

// File: rtl/cbr_ref_pkg.sv
package cbr_ref_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_SETUP,
    SEQ_RASLO,
    SEQ_PRE
  } seq_st_e;

  typedef enum logic [1:0] {
    MODE_PAUSE,
    MODE_INIT,
    MODE_RUN
  } mode_e;
endpackage

// File: rtl/cbr_span_ctr.sv
module cbr_span_ctr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST)  cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbr_debt_ctr.sv
module cbr_debt_ctr #(
  parameter int unsigned LIMIT = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         inc_i,
  input  logic                         dec_i,
  output logic                         pending_o,
  output logic                         full_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] MAXV = W'(LIMIT);

  logic [W-1:0] debt_q;

  assign pending_o = (debt_q != '0);
  assign full_o    = (debt_q == MAXV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      debt_q <= '0;
    else if (clr_i)   debt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (debt_q != MAXV) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0)   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_ref_pkg::*;
#(
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 1,
  parameter int unsigned RAS_LOW_CYC = 6,
  parameter int unsigned RAS_PRE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic row_open_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned M1   = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int unsigned M2   = (RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST   = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST   = CW'(RAS_PRE_CYC - 1);
  localparam logic [CW-1:0] HOLD_CNT   = CW'(CHR_CYC);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE:  if (start_i) begin st_d = SEQ_WAIT; cnt_d = '0; end
      SEQ_WAIT:  if (!row_open_i) begin st_d = SEQ_SETUP; cnt_d = '0; end
      SEQ_SETUP: begin
        if (cnt_q == SETUP_LAST) begin st_d = SEQ_RASLO; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      SEQ_RASLO: begin
        if (cnt_q == LOW_LAST) begin st_d = SEQ_PRE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      SEQ_PRE: begin
        if (cnt_q == PRE_LAST) begin st_d = SEQ_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: begin st_d = SEQ_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o  = (st_q != SEQ_IDLE);
  assign done_o  = (st_q == SEQ_PRE) && (cnt_q == PRE_LAST);
  assign ras_n_o = !(st_q == SEQ_RASLO);
  assign cas_n_o = !((st_q == SEQ_SETUP) || ((st_q == SEQ_RASLO) && (cnt_q < HOLD_CNT)));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_ref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC        = 20000,
  parameter int unsigned INIT_CBR_NUM     = 8,
  parameter int unsigned REF_INTERVAL_CYC = 1560,
  parameter int unsigned IDLE_LIMIT_CYC   = 800000,
  parameter int unsigned CSR_CYC          = 1,
  parameter int unsigned CHR_CYC          = 1,
  parameter int unsigned RAS_LOW_CYC      = 6,
  parameter int unsigned RAS_PRE_CYC      = 4,
  parameter int unsigned DEBT_LIMIT       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_open_i,
  input  logic access_cycle_i,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ref_busy_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned IW = (INIT_CBR_NUM > 1) ? $clog2(INIT_CBR_NUM) : 1;
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CBR_NUM - 1);

  mode_e         mode_q;
  logic [IW-1:0] init_cnt_q;
  logic          seq_busy, seq_done, seq_start;
  logic          pause_hit, tick, idle_hit, idle_clr;
  logic          debt_pend, debt_full;
  logic          in_run;

  assign in_run = (mode_q == MODE_RUN);

  assign seq_start = !seq_busy &&
                     ((mode_q == MODE_INIT) || (in_run && debt_pend && ref_gnt_i));

  cbr_span_ctr #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mode_q != MODE_PAUSE),
    .en_i  (1'b1),
    .hit_o (pause_hit)
  );

  cbr_span_ctr #(.LIMIT(REF_INTERVAL_CYC)) u_interval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_run),
    .en_i  (1'b1),
    .hit_o (tick)
  );

  // own refresh activity and controller accesses both count as activity
  assign idle_clr = !in_run || seq_busy || access_cycle_i || seq_start;

  cbr_span_ctr #(.LIMIT(IDLE_LIMIT_CYC)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idle_clr),
    .en_i  (1'b1),
    .hit_o (idle_hit)
  );

  cbr_debt_ctr #(.LIMIT(DEBT_LIMIT)) u_debt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!in_run || idle_hit),
    .inc_i    (tick),
    .dec_i    (seq_done && in_run),
    .pending_o(debt_pend),
    .full_o   (debt_full)
  );

  cbr_strobe_seq #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (seq_start),
    .row_open_i(row_open_i),
    .busy_o    (seq_busy),
    .done_o    (seq_done),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_PAUSE;
      init_cnt_q <= '0;
    end else begin
      unique case (mode_q)
        MODE_PAUSE: if (pause_hit) begin
          mode_q     <= MODE_INIT;
          init_cnt_q <= '0;
        end
        MODE_INIT: if (seq_done) begin
          if (init_cnt_q == INIT_LAST) mode_q <= MODE_RUN;
          else                         init_cnt_q <= init_cnt_q + 1'b1;
        end
        MODE_RUN: if (idle_hit) begin
          mode_q     <= MODE_INIT;
          init_cnt_q <= '0;
        end
        default: mode_q <= MODE_PAUSE;
      endcase
    end
  end

  assign ref_req_o    = in_run && !seq_busy && debt_pend;
  assign ref_urgent_o = debt_full;
  assign ref_busy_o   = seq_busy;
  assign init_done_o  = in_run;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic row_open_i,
  input logic ref_gnt_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic ref_busy_o,
  input logic init_done_o,
  input logic ras_n_o,
  input logic cas_n_o
);
  assert_idle_strobes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_busy_o |-> (ras_n_o && cas_n_o));

  assert_req_after_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> init_done_o);

  assert_cas_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  assert_cas_up_at_ras_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> cas_n_o);

  assert_row_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> !$past(row_open_i));

  assert_urgent_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> (ref_req_o || ref_busy_o));

  assert_grant_taken_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i) |=> (ref_busy_o && !ref_req_o));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .row_open_i  (row_open_i),
  .ref_gnt_i   (ref_gnt_i),
  .ref_req_o   (ref_req_o),
  .ref_urgent_o(ref_urgent_o),
  .ref_busy_o  (ref_busy_o),
  .init_done_o (init_done_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o)
);

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
  localparam int P_PAUSE = 20;
  localparam int P_NINIT = 8;
  localparam int P_INTV  = 40;
  localparam int P_IDLE  = 600;
  localparam int P_CSR   = 2;
  localparam int P_CHR   = 2;
  localparam int P_RASLO = 5;
  localparam int P_PRE   = 3;
  localparam int P_LIM   = 3;

  logic clk, rst_ni, row_open, acc, gnt;
  logic req, urg, busy, idone, ras_n, cas_n;

  cbr_refresh_sched #(
    .PAUSE_CYC(P_PAUSE), .INIT_CBR_NUM(P_NINIT), .REF_INTERVAL_CYC(P_INTV),
    .IDLE_LIMIT_CYC(P_IDLE), .CSR_CYC(P_CSR), .CHR_CYC(P_CHR),
    .RAS_LOW_CYC(P_RASLO), .RAS_PRE_CYC(P_PRE), .DEBT_LIMIT(P_LIM)
  ) u_cbr_refresh_sched (
    .clk_i(clk), .rst_ni(rst_ni), .row_open_i(row_open), .access_cycle_i(acc),
    .ref_gnt_i(gnt), .ref_req_o(req), .ref_urgent_o(urg), .ref_busy_o(busy),
    .init_done_o(idone), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // behavioural reference: mode 0 pause, 1 init, 2 run; phase 0 idle .. 4 precharge
  int m_mode, m_pcnt, m_icnt, m_sph, m_scnt, m_debt, m_tcnt, m_idle;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_pcnt = 0; m_icnt = 0; m_sph = 0;
      m_scnt = 0; m_debt = 0; m_tcnt = 0; m_idle = 0;
    end else begin
      bit s_idle, done, start, tick, expire;
      int n_sph, n_scnt;
      s_idle = (m_sph == 0);
      done   = (m_sph == 4) && (m_scnt == P_PRE - 1);
      start  = s_idle && ((m_mode == 1) || (m_mode == 2 && m_debt > 0 && gnt));
      tick   = (m_mode == 2) && (m_tcnt == P_INTV - 1);
      expire = (m_mode == 2) && s_idle && !acc && !start && (m_idle == P_IDLE - 1);
      if (m_mode != 2 || !s_idle || acc || start || expire) m_idle = 0;
      else m_idle++;
      m_tcnt = (m_mode != 2 || tick) ? 0 : m_tcnt + 1;
      if (m_mode != 2 || expire) m_debt = 0;
      else if (tick && !done) m_debt = (m_debt < P_LIM) ? m_debt + 1 : m_debt;
      else if (done && !tick) m_debt--;
      n_sph = m_sph; n_scnt = m_scnt;
      case (m_sph)
        0: if (start) begin n_sph = 1; n_scnt = 0; end
        1: if (!row_open) begin n_sph = 2; n_scnt = 0; end
        2: if (m_scnt == P_CSR - 1) begin n_sph = 3; n_scnt = 0; end else n_scnt++;
        3: if (m_scnt == P_RASLO - 1) begin n_sph = 4; n_scnt = 0; end else n_scnt++;
        default: if (m_scnt == P_PRE - 1) begin n_sph = 0; n_scnt = 0; end else n_scnt++;
      endcase
      case (m_mode)
        0: if (m_pcnt == P_PAUSE - 1) begin m_mode = 1; m_icnt = 0; m_pcnt = 0; end
           else m_pcnt++;
        1: if (done) begin
             if (m_icnt == P_NINIT - 1) m_mode = 2; else m_icnt++;
           end
        default: if (expire) begin m_mode = 1; m_icnt = 0; end
      endcase
      if (m_mode != 0) m_pcnt = 0;
      m_sph = n_sph; m_scnt = n_scnt;
    end
  end

  // per-cycle compare plus strobe-shape monitors
  int cyc = 0, first_cas = -1, ras_falls = 0;
  int cas_lead = 0, ras_w = 0, cas_in_ras = 0, since_rise = 0;
  bit seen_rise = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;

  always @(posedge clk) begin
    #2;
    if (rst_ni) cyc++;
    chk(cas_n === !(m_sph == 2 || (m_sph == 3 && m_scnt < P_CHR)), "R4 cas_n", cas_n,
        !(m_sph == 2 || (m_sph == 3 && m_scnt < P_CHR)));
    chk(ras_n === !(m_sph == 3), "R5 ras_n", ras_n, !(m_sph == 3));
    chk(busy === (m_sph != 0), "R12 busy", busy, m_sph != 0);
    chk(req === (m_mode == 2 && m_sph == 0 && m_debt > 0), "R7 req", req,
        m_mode == 2 && m_sph == 0 && m_debt > 0);
    chk(urg === (m_debt == P_LIM), "R9 urgent", urg, m_debt == P_LIM);
    chk(idone === (m_mode == 2), "R3 init_done", idone, m_mode == 2);
    if (p_cas && !cas_n) begin
      chk(!row_open, "R6 row open at CAS fall", row_open, 0);
      if (seen_rise) chk(since_rise >= P_PRE, "R5 precharge", since_rise, P_PRE);
      if (first_cas < 0) begin
        first_cas = cyc;
        chk(cyc > P_PAUSE, "R2 pause", cyc, P_PAUSE + 2);
      end
    end
    if (p_ras && !ras_n) begin
      chk(cas_lead == P_CSR, "R4 CAS lead", cas_lead, P_CSR);
      ras_falls++;
    end
    if (!p_ras && ras_n) begin
      chk(ras_w == P_RASLO, "R5 RAS width", ras_w, P_RASLO);
      chk(cas_in_ras == P_CHR, "R4 CAS hold", cas_in_ras, P_CHR);
      ras_w = 0; cas_in_ras = 0; since_rise = 0; seen_rise = 1;
    end
    if (!ras_n) begin ras_w++; if (!cas_n) cas_in_ras++; end
    else since_rise++;
    if (!cas_n && ras_n) cas_lead++; else if (cas_n) cas_lead = 0;
    p_ras = ras_n; p_cas = cas_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    bit dropped;
    rst_ni = 1'b0; row_open = 1'b0; acc = 1'b0; gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
    chk(!req && !busy && !idone, "R1 flags in reset", {req, busy, idone}, 0);
    rst_ni = 1'b1;

    // R2/R3: pause then init without any grant
    for (int i = 0; i < 2000 && !idone; i++) @(negedge clk);
    chk(ras_falls == P_NINIT, "R3 init cycle count", ras_falls, P_NINIT);

    // R7/R9: withhold grant, debt climbs to limit
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      acc = (i % 50 == 0);
    end
    acc = 1'b0;
    chk(urg, "R9 urgent at limit", urg, 1);
    chk(req, "R7 request held without grant", req, 1);

    // R6: grant while the row is still open
    row_open = 1'b1;
    @(negedge clk); gnt = 1'b1;
    @(negedge clk); gnt = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(cas_n && busy, "R6 CAS held off while row open", {cas_n, busy}, 3);
    end
    row_open = 1'b0;

    // R8: keep granting until debt paid
    gnt = 1'b1;
    for (int i = 0; i < 300 && (req || busy || urg); i++) begin
      @(negedge clk);
      acc = (i % 50 == 0);
    end
    acc = 1'b0;
    chk(!req && !urg, "R8 debt paid off", {req, urg}, 0);

    // R11: accesses spaced below the idle limit keep init_done
    gnt = 1'b0;
    dropped = 0;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      acc = (i % 100 == 0);
      if (!idone) dropped = 1;
    end
    acc = 1'b0;
    chk(!dropped, "R11 accesses keep init", dropped, 0);

    // R10: silence past the idle limit forces re-init
    for (int i = 0; i < 800 && idone; i++) @(negedge clk);
    chk(!idone, "R10 re-init entered", idone, 0);
    base = ras_falls;
    for (int i = 0; i < 2000 && !idone; i++) @(negedge clk);
    chk(ras_falls - base == P_NINIT, "R10 re-init cycles", ras_falls - base, P_NINIT);

    // R12: grant with no pending debt does nothing
    gnt = 1'b1;
    dropped = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy) dropped = 1;
    end
    gnt = 1'b0;
    chk(!dropped, "R12 grant ignored without request", dropped, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule